// File: doc/BRIEF.md
# Page Write Buffer with Commit Timer

This block sits behind the byte-level decoder of a serial memory slave. It collects the data bytes of one write transfer into a page buffer and then copies them into the memory array as a single internal write cycle. The upstream decoder reports four kinds of event: the start of a write transfer for this device, the word address byte, each data byte, and the bus STOP. The block returns an acknowledge decision for each data byte, raises a busy flag for the length of the internal write cycle, and drives a memory write port while the buffer is being copied.

Only the in-page part of the address moves as bytes arrive, so a transfer longer than one page wraps around and overwrites bytes it sent earlier. Nothing reaches the array until STOP arrives. A write-protect input stops programming by refusing to acknowledge data. The nonvolatile programming time is modelled by a counter of system clocks.

Top module: `wpb_top`

## Requirements
- R1: `density_i` selects the array size: 0 gives 7 address bits (`word_i[6:0]`) with an 8-byte page. 1 gives 8 bits (`word_i`) and 2 gives 9 bits (`{blk_i[0],word_i}`). 3 gives 10 bits (`{blk_i[1:0],word_i}`) and 4 gives 11 bits (`{blk_i,word_i}`). Codes 1 to 4 use a 16-byte page. `mem_addr_o` bits above the selected width are zero.
- R2: After each accepted data byte, only the in-page bits of the address pointer (3 bits for an 8-byte page, 4 bits for a 16-byte page) advance by one. The upper bits stay fixed.
- R3: If more bytes than the page size arrive before STOP, the in-page pointer wraps, and the later byte replaces the earlier one at the same position.
- R4: A STOP after at least one accepted data byte starts a commit. The commit writes each received page position exactly once, in ascending address order, with the last byte received for that position.
- R5: `busy_o` rises in the cycle after the STOP strobe that starts a commit. It stays high for page size plus `WR_CYCLES` clock cycles. `mem_we_o` is only high while `busy_o` is high.
- R6: While `busy_o` is high, all input strobes are ignored, and every data byte gets `ack_o`=0.
- R7: While `wp_i` is high, data bytes get `ack_o`=0 and are not buffered. A STOP then starts no write, and `busy_o` stays low.
- R8: `ack_vld_o` pulses one cycle after every `data_vld_i` strobe. `ack_o`=1 marks an accepted byte. A data byte that arrives before any word address in the current transfer is refused.
- R9: A transfer with a word address but no data bytes before STOP leaves `busy_o` low and writes nothing.
- R10: A new `wr_start_i` clears all bytes buffered so far. Bytes from a transfer that ended without STOP are never written.
- R11: After reset, `busy_o`, `mem_we_o` and `ack_vld_o` are low.
- R12: A single data byte followed by STOP writes exactly that one byte to its address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| density_i | input | 3 | Array size code (0..4) |
| wp_i | input | 1 | Write protect |
| wr_start_i | input | 1 | Strobe: write transfer addressed to this device begins |
| addr_vld_i | input | 1 | Strobe: word address byte present |
| blk_i | input | 3 | Block-select bits taken from the slave address |
| word_i | input | 8 | Word address byte |
| data_vld_i | input | 1 | Strobe: data byte present |
| data_i | input | 8 | Data byte |
| stop_i | input | 1 | Strobe: bus STOP seen |
| ack_vld_o | output | 1 | Acknowledge decision valid |
| ack_o | output | 1 | 1 = acknowledge, 0 = refuse |
| busy_o | output | 1 | Internal write cycle in progress |
| mem_we_o | output | 1 | Array write enable |
| mem_addr_o | output | 11 | Array write address |
| mem_data_o | output | 8 | Array write data |

## Verification
The assertions assume that every strobe lasts one cycle and that no two strobes arrive in the same cycle. They also assume that `density_i` does not change during a transfer or a commit. Both hold for a byte decoder that emits one event per bus byte. The bench drives each event as a single-cycle pulse with idle cycles between events. It changes `density_i` and `wp_i` only while the block is idle. It keeps `WR_CYCLES` short, so that several complete commits run, including ones where strobes are sent in the middle of a commit.

// File: rtl/wpb_pkg.sv
package wpb_pkg;
  typedef enum logic [2:0] {
    DEN_1K  = 3'd0,
    DEN_2K  = 3'd1,
    DEN_4K  = 3'd2,
    DEN_8K  = 3'd3,
    DEN_16K = 3'd4
  } wpb_dens_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_XFER   = 2'd1,
    ST_COMMIT = 2'd2,
    ST_PROG   = 2'd3
  } wpb_state_e;

  // number of significant address bits for a density code
  function automatic int unsigned addr_bits_f(logic [2:0] d);
    case (d)
      DEN_1K:  return 7;
      DEN_2K:  return 8;
      DEN_4K:  return 9;
      DEN_8K:  return 10;
      default: return 11;
    endcase
  endfunction
endpackage

// File: rtl/wpb_addr_ptr.sv
module wpb_addr_ptr #(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned IDX_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              adv_i,
  input  logic [IDX_W-1:0]  pmask_i,
  output logic [ADDR_W-1:0] ptr_o
);
  logic [ADDR_W-1:0] ptr_q, pm_ext, nxt;

  assign pm_ext = ADDR_W'(pmask_i);
  // in-page increment only; upper bits held
  assign nxt    = (ptr_q & ~pm_ext) | ((ptr_q + ADDR_W'(1)) & pm_ext);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ptr_q <= '0;
    else if (load_i) ptr_q <= addr_i;
    else if (adv_i)  ptr_q <= nxt;
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/wpb_page_store.sv
module wpb_page_store #(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned PAGE_MAX = 16,
  localparam int unsigned IDX_W   = $clog2(PAGE_MAX)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              wr_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_vld_o,
  output logic              any_vld_o
);
  logic [DATA_W-1:0]   data_q [PAGE_MAX];
  logic [PAGE_MAX-1:0] vld_q;

  for (genvar g = 0; g < PAGE_MAX; g++) begin : g_ent
    logic hit;
    assign hit = wr_i && (wr_idx_i == IDX_W'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        data_q[g] <= '0;
        vld_q[g]  <= 1'b0;
      end else if (clr_i) begin
        vld_q[g]  <= 1'b0;
      end else if (hit) begin
        data_q[g] <= wr_data_i;
        vld_q[g]  <= 1'b1;
      end
    end
  end

  assign rd_data_o = data_q[rd_idx_i];
  assign rd_vld_o  = vld_q[rd_idx_i];
  assign any_vld_o = |vld_q;
endmodule

// File: rtl/wpb_commit_fsm.sv
module wpb_commit_fsm
  import wpb_pkg::*;
#(
  parameter int unsigned PAGE_MAX  = 16,
  parameter int unsigned WR_CYCLES = 500000,
  localparam int unsigned IDX_W    = $clog2(PAGE_MAX),
  localparam int unsigned CNT_W    = (WR_CYCLES > 2) ? $clog2(WR_CYCLES) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_start_i,
  input  logic             addr_vld_i,
  input  logic             data_vld_i,
  input  logic             stop_i,
  input  logic             wp_i,
  input  logic             any_vld_i,
  input  logic [IDX_W-1:0] pmask_i,
  output logic             clr_o,
  output logic             load_o,
  output logic             accept_o,
  output logic             busy_o,
  output logic             scan_act_o,
  output logic [IDX_W-1:0] scan_o,
  output logic             ack_vld_o,
  output logic             ack_o
);
  wpb_state_e       st_q, st_d;
  logic             addr_ok_q;
  logic [IDX_W-1:0] scan_q;
  logic [CNT_W-1:0] cnt_q;
  logic             idle_ok;

  assign busy_o     = (st_q == ST_COMMIT) || (st_q == ST_PROG);
  assign idle_ok    = !busy_o;
  assign clr_o      = idle_ok && wr_start_i;
  assign load_o     = (st_q == ST_XFER) && addr_vld_i && !wr_start_i && !stop_i;
  assign accept_o   = (st_q == ST_XFER) && addr_ok_q && data_vld_i && !wp_i
                      && !wr_start_i && !stop_i && !addr_vld_i;
  assign scan_act_o = (st_q == ST_COMMIT);
  assign scan_o     = scan_q;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE:   if (wr_start_i) st_d = ST_XFER;
      ST_XFER: begin
        if (stop_i)          st_d = any_vld_i ? ST_COMMIT : ST_IDLE;
        else if (wr_start_i) st_d = ST_XFER;
      end
      ST_COMMIT: if (scan_q == pmask_i) st_d = ST_PROG;
      ST_PROG:   if (cnt_q == CNT_W'(WR_CYCLES - 1)) st_d = ST_IDLE;
      default:   st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      addr_ok_q <= 1'b0;
      scan_q    <= '0;
      cnt_q     <= '0;
      ack_vld_o <= 1'b0;
      ack_o     <= 1'b0;
    end else begin
      st_q      <= st_d;
      ack_vld_o <= data_vld_i;
      ack_o     <= accept_o;
      if (clr_o)       addr_ok_q <= 1'b0;
      else if (load_o) addr_ok_q <= 1'b1;
      if (st_q == ST_XFER && st_d == ST_COMMIT) scan_q <= '0;
      else if (st_q == ST_COMMIT)               scan_q <= scan_q + IDX_W'(1);
      if (st_q == ST_COMMIT)    cnt_q <= '0;
      else if (st_q == ST_PROG) cnt_q <= cnt_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/wpb_top.sv
module wpb_top
  import wpb_pkg::*;
#(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned BLK_W     = 3,
  parameter int unsigned PAGE_MAX  = 16,
  parameter int unsigned WR_CYCLES = 500000,
  localparam int unsigned ADDR_W   = DATA_W + BLK_W,
  localparam int unsigned IDX_W    = $clog2(PAGE_MAX)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        density_i,
  input  logic              wp_i,
  input  logic              wr_start_i,
  input  logic              addr_vld_i,
  input  logic [BLK_W-1:0]  blk_i,
  input  logic [DATA_W-1:0] word_i,
  input  logic              data_vld_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              stop_i,
  output logic              ack_vld_o,
  output logic              ack_o,
  output logic              busy_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_data_o
);
  logic [IDX_W-1:0]  pmask, scan;
  logic [ADDR_W-1:0] amask, full_addr, ptr;
  logic              clr, load, accept, any_vld, scan_act, rd_vld;

  // 1K density uses a half-size page
  assign pmask     = (density_i == DEN_1K) ? IDX_W'(PAGE_MAX/2 - 1) : IDX_W'(PAGE_MAX - 1);
  assign amask     = ADDR_W'((ADDR_W+1)'(1) << addr_bits_f(density_i)) - ADDR_W'(1);
  assign full_addr = {blk_i, word_i} & amask;

  wpb_addr_ptr #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_ptr (
    .clk_i, .rst_ni,
    .load_i  (load),
    .addr_i  (full_addr),
    .adv_i   (accept),
    .pmask_i (pmask),
    .ptr_o   (ptr)
  );

  wpb_page_store #(.DATA_W(DATA_W), .PAGE_MAX(PAGE_MAX)) u_store (
    .clk_i, .rst_ni,
    .clr_i     (clr),
    .wr_i      (accept),
    .wr_idx_i  (ptr[IDX_W-1:0] & pmask),
    .wr_data_i (data_i),
    .rd_idx_i  (scan),
    .rd_data_o (mem_data_o),
    .rd_vld_o  (rd_vld),
    .any_vld_o (any_vld)
  );

  wpb_commit_fsm #(.PAGE_MAX(PAGE_MAX), .WR_CYCLES(WR_CYCLES)) u_fsm (
    .clk_i, .rst_ni,
    .wr_start_i, .addr_vld_i, .data_vld_i, .stop_i, .wp_i,
    .any_vld_i  (any_vld),
    .pmask_i    (pmask),
    .clr_o      (clr),
    .load_o     (load),
    .accept_o   (accept),
    .busy_o     (busy_o),
    .scan_act_o (scan_act),
    .scan_o     (scan),
    .ack_vld_o  (ack_vld_o),
    .ack_o      (ack_o)
  );

  assign mem_we_o   = scan_act && rd_vld;
  assign mem_addr_o = (ptr & ~ADDR_W'(pmask)) | ADDR_W'(scan);
endmodule

// File: rtl/wpb_checker.sv
module wpb_checker #(
  parameter int unsigned ADDR_W = 11
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wp_i,
  input logic              data_vld_i,
  input logic              stop_i,
  input logic              ack_vld_o,
  input logic              ack_o,
  input logic              busy_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o
);
  assert_we_in_busy_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> busy_o);

  assert_busy_after_stop_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(stop_i));

  assert_nack_busy_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_vld_o && $past(busy_o)) |-> !ack_o);

  assert_nack_wp_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_vld_o && $past(wp_i)) |-> !ack_o);

  assert_ack_follows_data_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_vld_o |-> $past(data_vld_i));

  assert_ascending_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && $past(mem_we_o)) |-> (mem_addr_o > $past(mem_addr_o)));
endmodule

bind wpb_top wpb_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i, .rst_ni, .wp_i, .data_vld_i, .stop_i,
  .ack_vld_o, .ack_o, .busy_o, .mem_we_o, .mem_addr_o
);

// File: tb/wpb_top_bench.sv
module wpb_top_bench;
  localparam int WRC = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  density = 3'd1;
  logic        wp = 1'b0, wr_start = 1'b0, addr_vld = 1'b0, data_vld = 1'b0, stop = 1'b0;
  logic [2:0]  blk = '0;
  logic [7:0]  word = '0, data = '0;
  logic        ack_vld, ack, busy, mem_we;
  logic [10:0] mem_addr;
  logic [7:0]  mem_data;

  int n_run = 0, n_fail = 0;
  bit done = 0;
  logic [18:0] exp_q [$];

  always #10 clk = ~clk;

  wpb_top #(.WR_CYCLES(WRC)) u_wpb_top (
    .clk_i(clk), .rst_ni(rst_n), .density_i(density), .wp_i(wp),
    .wr_start_i(wr_start), .addr_vld_i(addr_vld), .blk_i(blk), .word_i(word),
    .data_vld_i(data_vld), .data_i(data), .stop_i(stop),
    .ack_vld_o(ack_vld), .ack_o(ack), .busy_o(busy),
    .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_data_o(mem_data)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor: array writes
  always @(negedge clk) begin
    if (rst_n && mem_we) begin
      if (exp_q.size() == 0) chk(0, "R4 unexpected write", {13'd0, mem_addr, mem_data}, 0);
      else begin
        logic [18:0] e;
        e = exp_q.pop_front();
        chk({mem_addr, mem_data} == e, "R4 write addr/data", {13'd0, mem_addr, mem_data}, {13'd0, e});
      end
    end
  end

  task automatic pulse_start();
    wr_start = 1; @(negedge clk); wr_start = 0; @(negedge clk);
  endtask

  task automatic pulse_addr(input logic [2:0] b, input logic [7:0] w);
    blk = b; word = w; addr_vld = 1; @(negedge clk); addr_vld = 0; @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] d, input bit exp_ack, input string req);
    data = d; data_vld = 1; @(negedge clk); data_vld = 0;
    chk(ack_vld === 1'b1, req, {31'd0, ack_vld}, 1);
    chk(ack === exp_ack, req, {31'd0, ack}, {31'd0, exp_ack});
    @(negedge clk);
  endtask

  // STOP, then measure busy length and confirm all expected writes seen
  task automatic send_stop(input int exp_busy, input string req);
    int n;
    stop = 1; @(negedge clk); stop = 0;
    n = 0;
    while (busy === 1'b1 && n < 1000) begin n++; @(negedge clk); end
    chk(n == exp_busy, req, n, exp_busy);
    chk(exp_q.size() == 0, {req, " pending writes"}, exp_q.size(), 0);
    @(negedge clk);
  endtask

  function automatic logic [10:0] model_addr(input int d, input logic [2:0] b, input logic [7:0] w);
    int bits; logic [10:0] full;
    bits = 7 + d;
    full = {b, w};
    return full & 11'((1 << bits) - 1);
  endfunction

  // full page write with expected queue computed from the requirements
  task automatic page_write(input int d, input logic [2:0] b, input logic [7:0] w, input int nbytes,
                            input logic [7:0] seed, input string req);
    int psz, idx; logic [10:0] base; logic [7:0] val [16]; bit v [16];
    psz = (d == 0) ? 8 : 16;
    base = model_addr(d, b, w);
    idx = int'(base) % psz;
    base = base - 11'(idx);
    for (int i = 0; i < 16; i++) v[i] = 0;
    density = 3'(d);
    pulse_start();
    pulse_addr(b, w);
    for (int i = 0; i < nbytes; i++) begin
      logic [7:0] dv;
      dv = seed + 8'(i * 7);
      send_byte(dv, 1, req);
      val[idx] = dv; v[idx] = 1;
      idx = (idx + 1) % psz;
    end
    for (int i = 0; i < psz; i++)
      if (v[i]) exp_q.push_back({base + 11'(i), val[i]});
    send_stop(psz + WRC, {req, " busy length"});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(busy === 0, "R11 busy", {31'd0, busy}, 0);
    chk(mem_we === 0, "R11 mem_we", {31'd0, mem_we}, 0);
    chk(ack_vld === 0, "R11 ack_vld", {31'd0, ack_vld}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R12 byte write, 2K
    page_write(1, 3'd0, 8'h35, 1, 8'hA5, "R12");
    // R2 16K in-page wrap of low bits, upper bits held
    page_write(4, 3'd5, 8'h3C, 6, 8'h11, "R2");
    // R3 overflow overwrite
    page_write(1, 3'd0, 8'h10, 18, 8'h40, "R3");
    // R1 1K: 8-byte page, address masked to 7 bits
    page_write(0, 3'd7, 8'hFE, 10, 8'h80, "R1 1K");
    // R1 4K and 8K address assembly
    page_write(2, 3'd6, 8'h80, 2, 8'h21, "R1 4K");
    page_write(3, 3'd7, 8'h01, 1, 8'h33, "R1 8K");

    // R7 write protect
    density = 3'd1; wp = 1;
    pulse_start(); pulse_addr(0, 8'h20);
    send_byte(8'h55, 0, "R7");
    send_byte(8'h56, 0, "R7");
    send_stop(0, "R7 no busy");
    wp = 0;

    // R9 address only
    pulse_start(); pulse_addr(0, 8'h44);
    send_stop(0, "R9");

    // R8 data before address refused
    pulse_start();
    send_byte(8'h99, 0, "R8 no addr");
    send_stop(0, "R8 no write");

    // R10 aborted transfer discarded
    pulse_start(); pulse_addr(0, 8'h60);
    send_byte(8'h01, 1, "R10");
    send_byte(8'h02, 1, "R10");
    pulse_start(); pulse_addr(0, 8'h40);
    send_byte(8'h77, 1, "R10");
    exp_q.push_back({11'h040, 8'h77});
    send_stop(16 + WRC, "R10");

    // R6 strobes ignored during busy
    pulse_start(); pulse_addr(0, 8'h08);
    send_byte(8'hC3, 1, "R6 setup");
    exp_q.push_back({11'h008, 8'hC3});
    stop = 1; @(negedge clk); stop = 0;
    chk(busy === 1, "R5 busy after stop", {31'd0, busy}, 1);
    pulse_start(); pulse_addr(0, 8'h50);
    send_byte(8'hEE, 0, "R6 nack in busy");
    while (busy === 1'b1) @(negedge clk);
    chk(exp_q.size() == 0, "R6 commit unaffected", exp_q.size(), 0);
    // wr_start was ignored, so STOP must not start anything
    send_stop(0, "R6 start ignored");
    send_byte(8'hEF, 0, "R6 no transfer open");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule